// File: doc/BRIEF.md
# Delayed Start Clock Output Gate

This block passes a generated clock onto two identical output copies under control of an active-low enable. The enable, the reference tick and the mode select are all asynchronous to the generated clock, so each one is brought into that domain through a synchronizer before it is used. Once enable is seen low, the block counts rising edges of the reference tick. Only after the count for the selected mode has been reached does it let the generated clock through, which gives the upstream frequency loop time to settle.

When enable is released, the gate closes only while the generated clock is low. A high pulse already in progress therefore finishes at full width, and the outputs then stay low. Releasing enable before the count completes clears the count. Changing the mode during the count restarts it at the new length.

A status output is high exactly while the gate is open and the outputs are toggling.

Top module: `dly_clk_gate`

## Requirements
- R1: After reset both clock outputs and the status output are low.
- R2: While `en_n` is 1, both clock outputs and `running_o` stay low, whatever `ref_in` and `sel_fast` are doing.
- R3: With `sel_fast` = 1 and `en_n` = 0, the outputs stay low through 399 reference rising edges and start toggling after the 400th.
- R4: With `sel_fast` = 0 and `en_n` = 0, the outputs stay low through 199 reference rising edges and start toggling after the 200th.
- R5: `clk_out_a` and `clk_out_b` carry the same waveform at all times.
- R6: Raising `en_n` while a clock output is high does not shorten that high phase, and the outputs are low within a few generated-clock cycles afterwards.
- R7: Raising `en_n` before the edge count completes clears the count, so a later enable waits for the full count again. A disable that arrives together with the final counting edge wins, and no pulse appears.
- R8: A change of `sel_fast` during the count restarts it, and the new mode's full edge count is then required.
- R9: `running_o` is high exactly while the gate lets the generated clock through to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_clk | input | 1 | Generated clock to be gated |
| ref_in | input | 1 | Reference tick, asynchronous; rising edges are counted |
| sel_fast | input | 1 | 1: long count (400 edges), 0: short count (200 edges) |
| en_n | input | 1 | Active-low output enable, asynchronous |
| clk_out_a | output | 1 | Gated clock, copy A |
| clk_out_b | output | 1 | Gated clock, copy B |
| running_o | output | 1 | High while the outputs are toggling |

## Verification
The start-up counter can finish in the same cycle that a disable arrives. The bench provokes this by raising `ref_in` for the last counting edge and `en_n` on the same generated-clock edge, so both pass through synchronizers of equal depth and reach the counter together. The outcome is judged at the ports: the status output must stay low, no output pulse may appear, and further reference edges must have no effect while the block is disabled.

// File: rtl/dly_clk_gate.sv
module dly_clk_gate #(
  parameter int FAST_CNT    = 400,
  parameter int SLOW_CNT    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic gen_clk,
  input  logic ref_in,
  input  logic sel_fast,
  input  logic en_n,
  output logic clk_out_a,
  output logic clk_out_b,
  output logic running_o
);
  localparam int MAXC = (FAST_CNT > SLOW_CNT) ? FAST_CNT : SLOW_CNT;
  localparam int CW   = $clog2(MAXC + 1);

  logic [SYNC_STAGES-1:0] en_sr, ref_sr, sel_sr;
  logic ref_q, mode_q, running, gate;
  logic [CW-1:0] cnt, limit;

  wire dis    = en_sr[SYNC_STAGES-1];
  wire ref_up = ref_sr[SYNC_STAGES-1] & ~ref_q;
  wire mode_s = sel_sr[SYNC_STAGES-1];
  wire mode_chg = mode_s != mode_q;

  assign limit = mode_s ? CW'(FAST_CNT) : CW'(SLOW_CNT);

  always_ff @(posedge gen_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sr  <= '1;
      ref_sr <= '0;
      sel_sr <= '0;
      ref_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      en_sr  <= {en_sr[SYNC_STAGES-2:0], en_n};
      ref_sr <= {ref_sr[SYNC_STAGES-2:0], ref_in};
      sel_sr <= {sel_sr[SYNC_STAGES-2:0], sel_fast};
      ref_q  <= ref_sr[SYNC_STAGES-1];
      mode_q <= mode_s;
    end
  end

  always_ff @(posedge gen_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (dis) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (!running) begin
      if (mode_chg)
        cnt <= '0;
      else if (ref_up) begin
        if (cnt == limit - CW'(1))
          running <= 1'b1;
        else
          cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(negedge gen_clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= running;
  end

  assign clk_out_a = gen_clk & gate;
  assign clk_out_b = gen_clk & gate;
  assign running_o = gate;

  a_r2_off_when_disabled: assert property (@(posedge gen_clk) disable iff (!rst_n)
    dis |=> !running);
  a_r7_count_cleared: assert property (@(posedge gen_clk) disable iff (!rst_n)
    dis |=> (cnt == '0));
  a_r8_mode_reload: assert property (@(posedge gen_clk) disable iff (!rst_n)
    (mode_chg && !running) |=> (cnt == '0));
  a_r3_count_bound: assert property (@(posedge gen_clk) disable iff (!rst_n)
    cnt < CW'(MAXC));
  a_r9_status_tracks_gate: assert property (@(posedge gen_clk) disable iff (!rst_n)
    running_o == running);
  a_r6_start_needs_enable: assert property (@(posedge gen_clk) disable iff (!rst_n)
    $rose(running) |-> $past(!dis));
endmodule

// File: tb/test_dly_clk_gate.sv
`timescale 1ns/1ps
module test_dly_clk_gate;
  logic rst_n = 1'b0, gen_clk = 1'b0, ref_in = 1'b0, sel_fast = 1'b0, en_n = 1'b1;
  logic clk_out_a, clk_out_b, running_o;
  int nchk = 0, nfail = 0;

  typedef struct { string tag; bit rdy; bit act; } exp_t;
  exp_t q[$];
  event done_ev;

  dly_clk_gate i_dly_clk_gate (
    .rst_n(rst_n), .gen_clk(gen_clk), .ref_in(ref_in), .sel_fast(sel_fast), .en_n(en_n),
    .clk_out_a(clk_out_a), .clk_out_b(clk_out_b), .running_o(running_o));

  always #2 gen_clk = ~gen_clk;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_st(string tag, bit rdy, bit act);
    exp_t it;
    it.tag = tag; it.rdy = rdy; it.act = act;
    q.push_back(it);
    @(done_ev);
  endtask

  initial forever begin
    exp_t it;
    logic ha, hb, la, lb, r;
    wait (q.size() != 0);
    it = q.pop_front();
    @(posedge gen_clk); #1;
    ha = clk_out_a; hb = clk_out_b; r = running_o;
    @(negedge gen_clk); #1;
    la = clk_out_a; lb = clk_out_b;
    chk({it.tag, " status"}, r, it.rdy);
    chk({it.tag, " toggling"}, int'(ha && !la), it.act);
    chk("R5 copies match", {ha, la}, {hb, lb});
    -> done_ev;
  end

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge gen_clk) ref_in = 1'b1;
      repeat (4) @(negedge gen_clk);
      ref_in = 1'b0;
      repeat (4) @(negedge gen_clk);
    end
  endtask

  task automatic enable_wait();
    @(negedge gen_clk) en_n = 1'b0;
    repeat (6) @(negedge gen_clk);
  endtask

  task automatic disable_wait();
    @(negedge gen_clk) en_n = 1'b1;
    repeat (8) @(negedge gen_clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge gen_clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge gen_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge gen_clk);
    expect_st("R1 reset", 0, 0);

    sel_fast = 1'b1; pulses(450);
    expect_st("R2 disabled fast", 0, 0);
    sel_fast = 1'b0; pulses(250);
    expect_st("R2 disabled slow", 0, 0);

    sel_fast = 1'b1; enable_wait();
    pulses(399); expect_st("R3 before 400th", 0, 0);
    pulses(1);   expect_st("R3 after 400th", 1, 1);
    expect_st("R5 running", 1, 1);

    @(posedge gen_clk); #0.5 en_n = 1'b1;
    #1 chk("R6 high phase kept", clk_out_a, 1);
    repeat (8) @(negedge gen_clk);
    expect_st("R6 after disable", 0, 0);

    sel_fast = 1'b0; enable_wait();
    pulses(199); expect_st("R4 before 200th", 0, 0);
    pulses(1);   expect_st("R4 after 200th", 1, 1);
    disable_wait();

    sel_fast = 1'b1; enable_wait();
    pulses(150); disable_wait(); enable_wait();
    pulses(399); expect_st("R7 restart before 400th", 0, 0);
    pulses(1);   expect_st("R7 restart after 400th", 1, 1);
    disable_wait();

    sel_fast = 1'b1; enable_wait();
    pulses(300);
    @(negedge gen_clk) sel_fast = 1'b0;
    repeat (6) @(negedge gen_clk);
    pulses(199); expect_st("R8 reload before 200th", 0, 0);
    pulses(1);   expect_st("R8 reload after 200th", 1, 1);
    disable_wait();

    sel_fast = 1'b0; enable_wait();
    pulses(199);
    @(negedge gen_clk) begin ref_in = 1'b1; en_n = 1'b1; end
    repeat (8) @(negedge gen_clk);
    ref_in = 1'b0;
    expect_st("R7 disable with last edge", 0, 0);
    pulses(5);
    expect_st("R7 disabled edges ignored", 0, 0);

    finish_run();
  end
endmodule